// File: doc/BRIEF.md
# Video Domain Power Sequencer

A hardware state machine that switches one video and display power domain on and off. A single-cycle request starts a sequence. The sequence steps through the isolation clamp, the power-switch control, a ladder of memory power-down controls, the domain reset and two clock enables. Each change comes in a fixed order, and each wait is measured in whole microseconds. The microsecond is derived from a cycles-per-microsecond prescaler, so one design serves any clock rate. It also stays exact over long chains of back-to-back waits.

The memory controls have three parts. Two words are each treated as 2-bit fields; only the upper bit of each field is driven. A third 8-bit group is driven one bit per step. All three are walked one step at a time with a fixed gap between steps. Power-down clamps the outputs first and removes power last. Power-up restores power first, then releases the reset and clamp, and enables the clocks. A controller above the block sees `powered`, `busy` and a one-cycle `done` pulse. Requests that arrive during a sequence are dropped. A request for the state the domain is already in completes at once.

Top module: `vdom_pwr_seq`

## Requirements
- R1: At reset the powered status follows the switch state given by INIT_SW_OFF. With the default (1) the outputs are: sw_off=1, iso_en=1, powered=0, both clock enables 0, dom_rst=0, busy=0, done=0. Every odd bit of both memory words is 1 (0xAAAAAAAA), and all bits of mem_grp_c are 1.
- R2: Power-down sets iso_en in the accepting cycle. Memory step k (0..39) sets its bit (GAP_US + STEP_US*k)*CYCLES_PER_US cycles after acceptance. Steps 0..15 map to mem_word_a bit 2k+1, steps 16..31 to mem_word_b bit 2(k-16)+1, and steps 32..39 to mem_grp_c bit k-32. At most one memory bit changes per cycle.
- R3: Power-down sets sw_off at (GAP_US + 40*STEP_US + TAIL_US)*CYCLES_PER_US cycles after acceptance. core_clk_en falls LONG_US microseconds after that, and bus_clk_en falls one cycle later.
- R4: Power-up clears sw_off in the accepting cycle. It then clears the same 40 memory bits in the same order and at the same offsets as R2.
- R5: Power-up asserts dom_rst at the R3 switch offset. iso_en falls one cycle later and dom_rst falls two cycles later. core_clk_en rises three cycles later and bus_clk_en four cycles later.
- R6: busy is high from the cycle after acceptance until the final clock-enable change. In that final cycle done is 1 for exactly one cycle, busy is 0 and powered takes its new value.
- R7: req_on, req_off and req_shut are ignored while busy is high; the running sequence keeps its timing.
- R8: An on request while powered, or an off request while off, gives done=1 and busy=0 one cycle later, with no change to any other output.
- R9: req_shut powers the domain down only if it is powered, otherwise it acts like R8. When an off or shut request arrives in the same cycle as an on request, the off or shut request wins.
- R10: iso_en is 1 in every cycle that sw_off is 1. A clock enable only rises while sw_off=0 and dom_rst=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_on | input | 1 | One-cycle power-up request |
| req_off | input | 1 | One-cycle power-down request |
| req_shut | input | 1 | One-cycle shutdown request (powers down only when on) |
| iso_en | output | 1 | Isolation clamp enable |
| sw_off | output | 1 | Power-switch disable |
| mem_word_a | output | WORD_W | First memory power-down word (odd bits used) |
| mem_word_b | output | WORD_W | Second memory power-down word (odd bits used) |
| mem_grp_c | output | GRP_W | Third memory power-down group |
| dom_rst | output | 1 | Domain reset |
| core_clk_en | output | 1 | Core clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| powered | output | 1 | Domain is on |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs full power-up and power-down sequences and compares every output in every cycle against arithmetic offsets. These runs tell apart the order of the memory steps, the gap length and any prescaler drift. The runs differ in how they start (on, off, shut) and in a stray request injected mid-sequence: during the memory ladder, during the tail, and during the long wait. Each of these shows whether busy really locks out new requests. Separate single-request cases cover each redundant request and the on-plus-off collision; these tell a no-op completion apart from a real sequence.

// File: rtl/vdom_pkg.sv
package vdom_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GAP,
    ST_MEM,
    ST_TAIL,
    ST_LONG,
    ST_DN_BUS,
    ST_UP_ISO,
    ST_UP_RREL,
    ST_UP_CORE,
    ST_UP_BUS
  } vdom_state_e;

  function automatic int unsigned max2(int unsigned x, int unsigned y);
    return (x > y) ? x : y;
  endfunction

  // cycle offset of memory step k from the accepting edge
  function automatic int unsigned step_cycle(int unsigned gap_us, int unsigned step_us,
                                             int unsigned cpu, int unsigned k);
    return (gap_us + step_us * k) * cpu;
  endfunction

endpackage

// File: rtl/vdom_us_timer.sv
module vdom_us_timer #(
  parameter int unsigned CYCLES_PER_US = 50,
  parameter int unsigned LEN_W         = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_us,
  output logic             expire
);
  localparam int unsigned PRE_W = (CYCLES_PER_US > 1) ? $clog2(CYCLES_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYCLES_PER_US - 1);

  logic [PRE_W-1:0] pre_q;
  logic [LEN_W-1:0] left_q;
  logic             run_q;
  logic             us_tick;

  assign us_tick = run_q && (pre_q == PRE_LAST);
  assign expire  = us_tick && (left_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      left_q <= '0;
      run_q  <= 1'b0;
    end else if (start) begin
      pre_q  <= '0;
      left_q <= len_us;
      run_q  <= 1'b1;
    end else if (run_q) begin
      if (us_tick) begin
        pre_q  <= '0;
        left_q <= left_q - LEN_W'(1);
        if (left_q == LEN_W'(1)) run_q <= 1'b0;
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  // R2
  tmr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start) |=> (left_q <= $past(left_q)));

endmodule

// File: rtl/vdom_mem_stepper.sv
module vdom_mem_stepper #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned GRP_W     = 8,
  parameter int unsigned IDX_W     = 6,
  parameter bit          INIT_DOWN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              step_set,
  input  logic [IDX_W-1:0]  step_idx,
  output logic [WORD_W-1:0] word_a,
  output logic [WORD_W-1:0] word_b,
  output logic [GRP_W-1:0]  grp_c
);
  localparam int unsigned FIELDS = WORD_W / 2;
  localparam int unsigned AW     = $clog2(WORD_W);
  localparam int unsigned CW     = $clog2(GRP_W);

  function automatic logic [WORD_W-1:0] odd_bits();
    logic [WORD_W-1:0] v;
    v = '0;
    for (int i = 1; i < int'(WORD_W); i += 2) v[i] = 1'b1;
    return v;
  endfunction

  int unsigned     k_u;
  logic            in_a, in_b;
  logic [AW-1:0]   pos_a, pos_b;
  logic [CW-1:0]   pos_c;

  always_comb begin
    k_u   = 32'(step_idx);
    in_a  = (k_u < FIELDS);
    in_b  = (k_u >= FIELDS) && (k_u < 2 * FIELDS);
    pos_a = AW'(2 * k_u + 1);
    pos_b = AW'(2 * (k_u - FIELDS) + 1);
    pos_c = CW'(k_u - 2 * FIELDS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_a <= INIT_DOWN ? odd_bits() : '0;
      word_b <= INIT_DOWN ? odd_bits() : '0;
      grp_c  <= INIT_DOWN ? '1 : '0;
    end else if (step_en) begin
      if (in_a)      word_a[pos_a] <= step_set;
      else if (in_b) word_b[pos_b] <= step_set;
      else           grp_c[pos_c]  <= step_set;
    end
  end

  // R2
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({word_a, word_b, grp_c} ^ $past({word_a, word_b, grp_c})) <= 1);

endmodule

// File: rtl/vdom_pwr_seq.sv
module vdom_pwr_seq #(
  parameter int unsigned CYCLES_PER_US = 50,
  parameter int unsigned GAP_US        = 20,
  parameter int unsigned STEP_US       = 5,
  parameter int unsigned TAIL_US       = 20,
  parameter int unsigned LONG_US       = 20000,
  parameter int unsigned WORD_W        = 32,
  parameter int unsigned GRP_W         = 8,
  parameter bit          INIT_SW_OFF   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_on,
  input  logic              req_off,
  input  logic              req_shut,
  output logic              iso_en,
  output logic              sw_off,
  output logic [WORD_W-1:0] mem_word_a,
  output logic [WORD_W-1:0] mem_word_b,
  output logic [GRP_W-1:0]  mem_grp_c,
  output logic              dom_rst,
  output logic              core_clk_en,
  output logic              bus_clk_en,
  output logic              powered,
  output logic              busy,
  output logic              done
);
  import vdom_pkg::*;

  localparam int unsigned NSTEPS = WORD_W + GRP_W;
  localparam int unsigned IDX_W  = $clog2(NSTEPS + 1);
  localparam int unsigned LEN_W  =
    $clog2(max2(max2(GAP_US, STEP_US), max2(TAIL_US, LONG_US)) + 1);

  vdom_state_e      state_q;
  logic             dir_down_q;
  logic [IDX_W-1:0] step_q;

  // named internal events
  logic             want_off, accept_dn, accept_up, noop_req;
  logic             tmr_expire, tmr_start, step_en, ladder_end;
  logic [LEN_W-1:0] tmr_len;

  always_comb begin
    want_off   = req_off | req_shut;
    accept_dn  = (state_q == ST_IDLE) && want_off && powered;
    accept_up  = (state_q == ST_IDLE) && req_on && !want_off && !powered;
    noop_req   = (state_q == ST_IDLE) &&
                 ((want_off && !powered) || (req_on && !want_off && powered));
    step_en    = tmr_expire && ((state_q == ST_GAP) ||
                 ((state_q == ST_MEM) && (step_q != IDX_W'(NSTEPS))));
    ladder_end = tmr_expire && (state_q == ST_MEM) && (step_q == IDX_W'(NSTEPS));
    tmr_start  = 1'b0;
    tmr_len    = '0;
    if (accept_dn || accept_up) begin
      tmr_start = 1'b1;
      tmr_len   = LEN_W'(GAP_US);
    end else if (step_en) begin
      tmr_start = 1'b1;
      tmr_len   = LEN_W'(STEP_US);
    end else if (ladder_end) begin
      tmr_start = 1'b1;
      tmr_len   = LEN_W'(TAIL_US);
    end else if (tmr_expire && (state_q == ST_TAIL) && dir_down_q) begin
      tmr_start = 1'b1;
      tmr_len   = LEN_W'(LONG_US);
    end
  end

  vdom_us_timer #(
    .CYCLES_PER_US (CYCLES_PER_US),
    .LEN_W         (LEN_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tmr_start),
    .len_us (tmr_len),
    .expire (tmr_expire)
  );

  vdom_mem_stepper #(
    .WORD_W    (WORD_W),
    .GRP_W     (GRP_W),
    .IDX_W     (IDX_W),
    .INIT_DOWN (INIT_SW_OFF)
  ) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .step_set (dir_down_q),
    .step_idx (step_q),
    .word_a   (mem_word_a),
    .word_b   (mem_word_b),
    .grp_c    (mem_grp_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      dir_down_q  <= 1'b0;
      step_q      <= '0;
      iso_en      <= INIT_SW_OFF;
      sw_off      <= INIT_SW_OFF;
      dom_rst     <= 1'b0;
      core_clk_en <= !INIT_SW_OFF;
      bus_clk_en  <= !INIT_SW_OFF;
      powered     <= !INIT_SW_OFF;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (step_en) step_q <= step_q + IDX_W'(1);
      unique case (state_q)
        ST_IDLE: begin
          if (accept_dn) begin
            iso_en     <= 1'b1;
            busy       <= 1'b1;
            dir_down_q <= 1'b1;
            step_q     <= '0;
            state_q    <= ST_GAP;
          end else if (accept_up) begin
            sw_off     <= 1'b0;
            busy       <= 1'b1;
            dir_down_q <= 1'b0;
            step_q     <= '0;
            state_q    <= ST_GAP;
          end else if (noop_req) begin
            done <= 1'b1;
          end
        end
        ST_GAP:  if (tmr_expire) state_q <= ST_MEM;
        ST_MEM:  if (ladder_end) state_q <= ST_TAIL;
        ST_TAIL: begin
          if (tmr_expire) begin
            if (dir_down_q) begin
              sw_off  <= 1'b1;
              state_q <= ST_LONG;
            end else begin
              dom_rst <= 1'b1;
              state_q <= ST_UP_ISO;
            end
          end
        end
        ST_LONG: begin
          if (tmr_expire) begin
            core_clk_en <= 1'b0;
            state_q     <= ST_DN_BUS;
          end
        end
        ST_DN_BUS: begin
          bus_clk_en <= 1'b0;
          busy       <= 1'b0;
          done       <= 1'b1;
          powered    <= 1'b0;
          state_q    <= ST_IDLE;
        end
        ST_UP_ISO: begin
          iso_en  <= 1'b0;
          state_q <= ST_UP_RREL;
        end
        ST_UP_RREL: begin
          dom_rst <= 1'b0;
          state_q <= ST_UP_CORE;
        end
        ST_UP_CORE: begin
          core_clk_en <= 1'b1;
          state_q     <= ST_UP_BUS;
        end
        ST_UP_BUS: begin
          bus_clk_en <= 1'b1;
          busy       <= 1'b0;
          done       <= 1'b1;
          powered    <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  iso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_off |-> iso_en);

  // R10
  clk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(core_clk_en) || $rose(bus_clk_en)) |-> (!sw_off && !dom_rst));

  // R5
  iso_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> dom_rst);

  // R5
  clk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_clk_en) |-> core_clk_en);

  // R3
  clk_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en) |-> (sw_off && bus_clk_en));

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  mem_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable({mem_word_a, mem_word_b, mem_grp_c}));

endmodule

// File: tb/tb_vdom_pwr_seq.sv
`timescale 1ns/1ps
module tb_vdom_pwr_seq;
  localparam int C     = 3;
  localparam int GAP   = 20;
  localparam int STEP  = 5;
  localparam int TAIL  = 20;
  localparam int LONG  = 40;
  localparam int NST   = 40;
  localparam int T_SW  = (GAP + STEP * NST + TAIL) * C;
  localparam int DN_END = T_SW + LONG * C + 1;
  localparam int UP_END = T_SW + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_on = 1'b0, req_off = 1'b0, req_shut = 1'b0;
  logic iso_en, sw_off, dom_rst, core_clk_en, bus_clk_en, powered, busy, done;
  logic [31:0] mem_word_a, mem_word_b;
  logic [7:0]  mem_grp_c;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vdom_pwr_seq #(
    .CYCLES_PER_US(C), .GAP_US(GAP), .STEP_US(STEP), .TAIL_US(TAIL),
    .LONG_US(LONG), .WORD_W(32), .GRP_W(8), .INIT_SW_OFF(1'b1)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off), .req_shut(req_shut),
    .iso_en(iso_en), .sw_off(sw_off), .mem_word_a(mem_word_a), .mem_word_b(mem_word_b),
    .mem_grp_c(mem_grp_c), .dom_rst(dom_rst), .core_clk_en(core_clk_en),
    .bus_clk_en(bus_clk_en), .powered(powered), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input logic [79:0] got, input logic [79:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int steps_done(int t);
    int k;
    if (t < GAP * C) return 0;
    k = (t - GAP * C) / (STEP * C) + 1;
    return (k > NST) ? NST : k;
  endfunction

  // bits k<n hold 'down', the rest hold the opposite value
  function automatic logic [71:0] exp_mem(int n, bit down);
    logic [31:0] a = '0, b = '0;
    logic [7:0]  c = '0;
    for (int k = 0; k < NST; k++) begin
      bit v = (k < n) ? down : !down;
      if (k < 16)      a[2*k+1]      = v;
      else if (k < 32) b[2*(k-16)+1] = v;
      else             c[k-32]       = v;
    end
    return {a, b, c};
  endfunction

  function automatic logic [71:0] mem_now();
    return {mem_word_a, mem_word_b, mem_grp_c};
  endfunction

  function automatic logic [4:0] ctl_now();
    return {iso_en, sw_off, dom_rst, core_clk_en, bus_clk_en};
  endfunction

  // drive one request set, then check every cycle of the sequence
  task automatic run_seq(input bit down, input bit r_on, input bit r_off, input bit r_sh,
                         input int poke_t, input bit p_on, input bit p_off, input bit p_sh,
                         input string tm, input string tc);
    int last;
    last = (down ? DN_END : UP_END) + 1;
    @(negedge clk);
    req_on = r_on; req_off = r_off; req_shut = r_sh;
    for (int t = 0; t <= last; t++) begin
      logic [4:0] ec;
      logic [2:0] es;
      int fin;
      @(negedge clk);
      req_on = 1'b0; req_off = 1'b0; req_shut = 1'b0;
      if (down) begin
        fin = DN_END;
        ec = {1'b1, t >= T_SW, 1'b0, t < T_SW + LONG * C, t < DN_END};
        es = {t < fin, t < fin, t == fin};
      end else begin
        fin = UP_END;
        ec = {t < T_SW + 1, 1'b0, (t >= T_SW) && (t < T_SW + 2), t >= T_SW + 3, t >= T_SW + 4};
        es = {t >= fin, t < fin, t == fin};
      end
      chk(tm, 80'(mem_now()), 80'(exp_mem(steps_done(t), down)));
      chk(tc, 80'(ctl_now()), 80'(ec));
      chk("R6 status", 80'({powered, busy, done}), 80'(es));
      chk("R10 interlock", 80'(sw_off && !iso_en), 80'(0));
      // R7: stray request while busy
      if (t == poke_t) begin
        req_on = p_on; req_off = p_off; req_shut = p_sh;
      end
    end
  endtask

  // R8 / R9: request that must complete at once with no output change
  task automatic noop(input bit r_on, input bit r_off, input bit r_sh, input string tag);
    logic [79:0] snap;
    @(negedge clk);
    snap = {mem_now(), ctl_now(), powered, 2'b00};
    req_on = r_on; req_off = r_off; req_shut = r_sh;
    @(negedge clk);
    req_on = 1'b0; req_off = 1'b0; req_shut = 1'b0;
    chk(tag, 80'({done, busy}), 80'(2'b10));
    chk(tag, {mem_now(), ctl_now(), powered, 2'b00}, snap);
    @(negedge clk);
    chk(tag, 80'({done, busy}), 80'(2'b00));
    chk(tag, {mem_now(), ctl_now(), powered, 2'b00}, snap);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mem", 80'(mem_now()), 80'({32'hAAAAAAAA, 32'hAAAAAAAA, 8'hFF}));
    chk("R1 ctl", 80'(ctl_now()), 80'(5'b11000));
    chk("R1 status", 80'({powered, busy, done}), 80'(3'b000));

    noop(1'b0, 1'b1, 1'b0, "R8 off-while-off");
    noop(1'b0, 1'b0, 1'b1, "R9 shut-while-off");
    noop(1'b1, 1'b1, 1'b0, "R9 on+off priority");

    // R4/R5 power-up, stray off during memory ladder (R7)
    run_seq(1'b0, 1'b1, 1'b0, 1'b0, 100, 1'b0, 1'b1, 1'b0, "R4 up mem", "R5 up ctl");
    noop(1'b1, 1'b0, 1'b0, "R8 on-while-on");
    // R2/R3 power-down, stray on in the first gap (R7)
    run_seq(1'b1, 1'b0, 1'b1, 1'b0, 30, 1'b1, 1'b0, 1'b0, "R2 dn mem", "R3 dn ctl");
    // power-up with stray shut in the tail (R7)
    run_seq(1'b0, 1'b1, 1'b0, 1'b0, T_SW - 10, 1'b0, 1'b0, 1'b1, "R4 up mem", "R5 up ctl");
    // R9 shutdown while on, with on+off in the long wait (R7)
    run_seq(1'b1, 1'b0, 1'b0, 1'b1, T_SW + 60, 1'b1, 1'b1, 1'b0, "R9 shut mem", "R9 shut ctl");
    noop(1'b0, 1'b0, 1'b1, "R9 shut-after-down");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule